// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software by requiring it to reload a 7-bit down-counter within a time window. The counter steps down once per prescaled tick: a fixed base divider (4096 clock cycles by default) is followed by a selectable power-of-two stage, from 1 to 128. Software arms the watchdog once. From then on the block issues a one-cycle system reset request in three cases: the counter falls from 0x40 to 0x3F; software reloads it while the count is still above a programmable window value; or software loads a value with bit 6 clear.

A sticky early-warning flag is raised when the count reaches 0x40. An interrupt line follows that flag once the interrupt has been enabled. A processor reaches the block through a single-cycle register port with three word registers. The control register holds the count and the arm bit. The configuration register holds the window value, the prescaler select and the interrupt enable. The status register holds the warning flag. The reset request also returns the block itself to its reset state, so the next boot finds it idle.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control reads 0x7F (count 0x7F, not armed), configuration reads 0x7F (window 0x7F, prescaler select 0, interrupt enable 0), status reads 0, and both the reset request and the interrupt are low.
- R2: A write to control restarts the prescaler and loads the prescaler select. The count then drops by one every BASE_DIV × 2^select cycles, counted from that write. It stops at 0x00 and does not wrap.
- R3: The arm bit, control bit 7, is sticky. Writing control with bit 7 clear leaves the block armed.
- R4: While armed, a decrement from 0x40 to 0x3F raises the reset request. While not armed, the counter passes 0x40 with no request.
- R5: A control write whose bit 6 is 0 raises the reset request if the block is armed or the same write arms it. The same write with the block unarmed raises no request.
- R6: A control write while armed raises the reset request if the current count is greater than the window, configuration bits 6:0. A write when the count is less than or equal to the window raises none.
- R7: The reset request lasts exactly one cycle. In the following cycle every register reads its R1 value.
- R8: The early-warning flag, status bit 0, is set when the count decrements from 0x41 to 0x40. This happens whether or not the block is armed and whether or not the interrupt is enabled.
- R9: Writing status with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R10: The interrupt is high exactly while the flag and the enable, configuration bit 9, are both set. The enable is sticky: writing bit 9 = 0 does not clear it.
- R11: The register map is word offset 0x0 for control, 0x4 for configuration (window in 6:0, interrupt enable in 9, prescaler select in 13:11) and 0x8 for status. Reads are combinational. Unused bits and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| wdg_rst_req | output | 1 | One-cycle system reset request |
| wdg_irq | output | 1 | Early-warning interrupt |

## Verification
The assertions assume that the write strobe lasts one cycle per access and that BASE_DIV is at least 2, so two prescaler ticks are never adjacent. They also assume that the only external source of the soft clear is the block's own reset request. The bench drives every write for exactly one cycle on the falling edge and uses a base divider of 4 so that whole count sequences are short. It changes the prescaler select only before a control write, which means every decrement lands on a cycle the bench can compute from the write.

// File: rtl/win_wdg_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register offsets and field positions of the
// window watchdog. Assumes a fixed 7-bit counter with its top bit as threshold.
package win_wdg_pkg;
    localparam int CNT_W  = 7;
    localparam int TB_W   = 3;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h8;

    localparam int CTRL_ARM_BIT  = 7;
    localparam int CFG_EWI_BIT   = 9;
    localparam int CFG_TB_LSB    = 11;
    localparam int STAT_FLAG_BIT = 0;

    localparam logic [CNT_W-1:0] CNT_INIT  = '1;
    localparam logic [CNT_W-1:0] CNT_THRESH = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] CNT_WARN_PRE = CNT_W'((1 << (CNT_W - 1)) + 1);

    typedef struct packed {
        logic [TB_W-1:0]  tb_sel;
        logic             ewi_en;
        logic [CNT_W-1:0] window;
    } wdg_cfg_t;
endpackage

// File: rtl/win_wdg_prescaler.sv
`timescale 1ns/1ps
// Prescaler: a base divider of BASE_DIV cycles followed by a power-of-two
// stage picked by tb_sel. Emits a one-cycle tick on each counter step.
// Assumes BASE_DIV >= 2. restart realigns both stages and reloads tb_sel;
// otherwise tb_sel is sampled at every base boundary.
module win_wdg_prescaler #(
    parameter int BASE_DIV = 4096,
    parameter int TB_W     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            restart,
    input  logic [TB_W-1:0] tb_sel,
    output logic            tick
);
    localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int PRE_W  = (1 << TB_W) - 1;
    localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

    logic [BASE_W-1:0] base_cnt;
    logic [PRE_W-1:0]  pre_cnt;
    logic [TB_W-1:0]   tb_eff;
    logic [PRE_W-1:0]  pre_mask;
    logic              base_wrap;

    // Mask of the low pre_cnt bits that must all be ones for a step.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            pre_mask[i] = (i < int'(tb_eff));
        end
    end

    // Step tick: end of a base period with the selected power-of-two phase.
    always_comb begin
        base_wrap = (base_cnt == BASE_LAST);
        tick      = base_wrap && ((pre_cnt & pre_mask) == pre_mask);
    end

    // Divider state: cleared on reset, realigned on restart, else counts.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            base_cnt <= '0;
            pre_cnt  <= '0;
            tb_eff   <= '0;
        end else if (restart) begin
            base_cnt <= '0;
            pre_cnt  <= '0;
            tb_eff   <= tb_sel;
        end else if (base_wrap) begin
            base_cnt <= '0;
            pre_cnt  <= pre_cnt + 1'b1;
            tb_eff   <= tb_sel;
        end else begin
            base_cnt <= base_cnt + 1'b1;
        end
    end

    // Two counter steps never fall on adjacent cycles.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/win_wdg_counter.sv
`timescale 1ns/1ps
// Counter core: the 7-bit down-counter, the sticky arm bit and the three
// violation checks (underflow past the threshold, early reload above the window,
// reload below the threshold). Registers the one-cycle reset request.
// Assumes soft_clr is driven from rst_req by the parent.
module win_wdg_counter
    import win_wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_arm,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic             rst_req
);
    logic early_reload;
    logic low_reload;
    logic underflow;
    logic violation;

    // Violation decode for the current cycle.
    always_comb begin
        early_reload = ctrl_we && armed && (cnt > window);
        low_reload   = ctrl_we && (armed || wr_arm) && !wr_cnt[CNT_W-1];
        underflow    = !ctrl_we && armed && tick && (cnt == CNT_THRESH);
        violation    = early_reload || low_reload || underflow;
    end

    // Count and arm state: reload on write, else step down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cnt   <= CNT_INIT;
            armed <= 1'b0;
        end else if (ctrl_we) begin
            cnt   <= wr_cnt;
            armed <= armed | wr_arm;
        end else if (tick && (cnt != '0)) begin
            cnt   <= cnt - 1'b1;
        end
    end

    // Reset request: one registered cycle per detected violation.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= violation;
        end
    end

    assert_count_never_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !soft_clr) |=> (cnt <= $past(cnt)));

    assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !soft_clr) |=> armed);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_state_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == CNT_INIT && !armed));
endmodule

// File: rtl/win_wdg_regs.sv
`timescale 1ns/1ps
// Register file: the configuration register (window, prescaler select,
// sticky interrupt enable), the early-warning flag, the interrupt output
// and the combinational read mux. Assumes one-cycle write strobes.
module win_wdg_regs
    import win_wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              armed,
    output wdg_cfg_t          cfg,
    output logic              warn_flag,
    output logic              irq,
    output logic [DATA_W-1:0] reg_rdata
);
    logic cfg_wr;
    logic stat_wr;
    logic ctrl_wr;
    logic flag_set;
    logic flag_clr;
    logic unused_wdata;

    // Write decode and flag events.
    always_comb begin
        ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
        cfg_wr   = reg_we && (reg_addr == ADDR_CFG);
        stat_wr  = reg_we && (reg_addr == ADDR_STAT);
        flag_set = tick && !ctrl_wr && (cnt == CNT_WARN_PRE);
        flag_clr = stat_wr && !reg_wdata[STAT_FLAG_BIT];
        unused_wdata = ^{reg_wdata[DATA_W-1:CFG_TB_LSB+TB_W], reg_wdata[CFG_EWI_BIT+1],
                         reg_wdata[CFG_EWI_BIT-1]};
    end

    // Configuration: window and select overwrite, interrupt enable only sets.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cfg.window <= CNT_INIT;
            cfg.tb_sel <= '0;
            cfg.ewi_en <= 1'b0;
        end else if (cfg_wr) begin
            cfg.window <= reg_wdata[CNT_W-1:0];
            cfg.tb_sel <= reg_wdata[CFG_TB_LSB +: TB_W];
            cfg.ewi_en <= cfg.ewi_en | reg_wdata[CFG_EWI_BIT];
        end
    end

    // Early-warning flag: set by the 0x41 to 0x40 step, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            warn_flag <= 1'b0;
        end else if (flag_set) begin
            warn_flag <= 1'b1;
        end else if (flag_clr) begin
            warn_flag <= 1'b0;
        end
    end

    // Interrupt line follows the enabled flag.
    assign irq = warn_flag && cfg.ewi_en;

    // Read mux: unmapped offsets and unused bits return zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CNT_W-1:0]    = cnt;
                reg_rdata[CTRL_ARM_BIT] = armed;
            end
            ADDR_CFG: begin
                reg_rdata[CNT_W-1:0]             = cfg.window;
                reg_rdata[CFG_EWI_BIT]           = cfg.ewi_en;
                reg_rdata[CFG_TB_LSB +: TB_W]    = cfg.tb_sel;
            end
            ADDR_STAT: reg_rdata[STAT_FLAG_BIT] = warn_flag;
            default:   reg_rdata = '0;
        endcase
    end

    assert_enable_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ewi_en && !soft_clr) |=> cfg.ewi_en);

    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_flag && !flag_clr && !soft_clr) |=> warn_flag);
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
// Window watchdog top: wires the prescaler, the counter core and the register
// file. The reset request doubles as a soft clear of all internal state.
// Assumes a single-cycle register port driven synchronously to clk.
module win_watchdog
    import win_wdg_pkg::*;
#(
    parameter int BASE_DIV = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdg_rst_req,
    output logic              wdg_irq
);
    wdg_cfg_t         cfg;
    logic             ctrl_we;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             warn_flag;
    logic             soft_clr;

    // Control write decode and self-clear loop.
    assign ctrl_we  = reg_we && (reg_addr == ADDR_CTRL);
    assign soft_clr = wdg_rst_req;

    win_wdg_prescaler #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .restart  (ctrl_we),
        .tb_sel   (cfg.tb_sel),
        .tick     (tick)
    );

    win_wdg_counter u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .tick     (tick),
        .ctrl_we  (ctrl_we),
        .wr_cnt   (reg_wdata[CNT_W-1:0]),
        .wr_arm   (reg_wdata[CTRL_ARM_BIT]),
        .window   (cfg.window),
        .cnt      (cnt),
        .armed    (armed),
        .rst_req  (wdg_rst_req)
    );

    win_wdg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tick      (tick),
        .cnt       (cnt),
        .armed     (armed),
        .cfg       (cfg),
        .warn_flag (warn_flag),
        .irq       (wdg_irq),
        .reg_rdata (reg_rdata)
    );

    assert_irq_implies_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_irq |-> warn_flag);
endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb;
    localparam int BDIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        wdg_rst_req;
    logic        wdg_irq;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic done = 1'b0;

    win_watchdog #(.BASE_DIV(BDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wdg_rst_req(wdg_rst_req), .wdg_irq(wdg_irq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (wdg_rst_req) pulses++;

    typedef struct packed {
        logic [2:0]  tb;
        logic [6:0]  start;
        logic [15:0] wait_cyc;
        logic [6:0]  expect_cnt;
    } vec_t;

    // R2 table: select, loaded count, cycles waited, expected count (base divider 4).
    localparam vec_t VECS [9] = '{
        '{3'd0, 7'h7F, 16'd3,   7'h7F},
        '{3'd0, 7'h7F, 16'd4,   7'h7E},
        '{3'd1, 7'h7F, 16'd7,   7'h7F},
        '{3'd1, 7'h7F, 16'd8,   7'h7E},
        '{3'd3, 7'h7F, 16'd64,  7'h7D},
        '{3'd2, 7'h10, 16'd33,  7'h0E},
        '{3'd7, 7'h7F, 16'd512, 7'h7E},
        '{3'd0, 7'h02, 16'd40,  7'h00},
        '{3'd0, 7'h41, 16'd12,  7'h3E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 4'h0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 4'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int p0;

        // R1 and R11: reset values and map.
        do_reset();
        rd(4'h0, v); check("R1 ctrl", v, 32'h7F);
        rd(4'h4, v); check("R1 cfg", v, 32'h7F);
        rd(4'h8, v); check("R1 stat", v, 32'h0);
        check("R1 irq", {31'h0, wdg_irq}, 32'h0);
        check("R1 rst", {31'h0, wdg_rst_req}, 32'h0);
        rd(4'hC, v); check("R11 unmapped", v, 32'h0);

        // R2 table walk, unarmed so no request may appear (R4 for the last row).
        foreach (VECS[i]) begin
            do_reset();
            p0 = pulses;
            wr(4'h4, {18'h0, VECS[i].tb, 11'h07F});
            wr(4'h0, {25'h0, VECS[i].start});
            repeat (int'(VECS[i].wait_cyc)) @(negedge clk);
            rd(4'h0, v); check("R2 count", v, {25'h0, VECS[i].expect_cnt});
            check("R4 unarmed no request", pulses - p0, 0);
        end

        // R8: flag set at 0x40 while unarmed and interrupt disabled.
        do_reset();
        wr(4'h0, 32'h41);
        repeat (4) @(negedge clk);
        rd(4'h8, v); check("R8 flag unarmed", v, 32'h1);
        check("R8 irq stays low", {31'h0, wdg_irq}, 32'h0);

        // R10 and R9: enable, stickiness, clear semantics.
        do_reset();
        wr(4'h4, 32'h27F);
        rd(4'h4, v); check("R11 cfg readback", v, 32'h27F);
        wr(4'h0, 32'h41);
        repeat (4) @(negedge clk);
        check("R10 irq on flag", {31'h0, wdg_irq}, 32'h1);
        wr(4'h4, 32'h07F);
        rd(4'h4, v); check("R10 enable sticky", v, 32'h27F);
        wr(4'h8, 32'h1);
        rd(4'h8, v); check("R9 write one ignored", v, 32'h1);
        check("R10 irq held", {31'h0, wdg_irq}, 32'h1);
        wr(4'h8, 32'h0);
        rd(4'h8, v); check("R9 write zero clears", v, 32'h0);
        check("R10 irq drops", {31'h0, wdg_irq}, 32'h0);

        // R3: arm bit is sticky.
        do_reset();
        wr(4'h0, 32'hFF);
        rd(4'h0, v); check("R3 armed", v, 32'hFF);
        wr(4'h0, 32'h7F);
        check("R3 no request", {31'h0, wdg_rst_req}, 32'h0);
        rd(4'h0, v); check("R3 still armed", v, 32'hFF);

        // R4 and R7: underflow while armed.
        do_reset();
        wr(4'h0, 32'hC1);
        repeat (7) @(negedge clk);
        rd(4'h0, v); check("R4 at threshold", v, 32'hC0);
        rd(4'h8, v); check("R8 flag armed", v, 32'h1);
        check("R4 no early request", {31'h0, wdg_rst_req}, 32'h0);
        @(negedge clk);
        check("R4 underflow request", {31'h0, wdg_rst_req}, 32'h1);
        @(negedge clk);
        check("R7 one cycle", {31'h0, wdg_rst_req}, 32'h0);
        rd(4'h0, v); check("R7 ctrl reset", v, 32'h7F);
        rd(4'h8, v); check("R7 stat reset", v, 32'h0);

        // R5: loads below the threshold.
        do_reset();
        wr(4'h0, 32'hBF);
        check("R5 arming low load", {31'h0, wdg_rst_req}, 32'h1);
        @(negedge clk);
        rd(4'h0, v); check("R7 ctrl after R5", v, 32'h7F);
        do_reset();
        wr(4'h0, 32'hFF);
        wr(4'h0, 32'h20);
        check("R5 armed low load", {31'h0, wdg_rst_req}, 32'h1);
        do_reset();
        wr(4'h0, 32'h3F);
        check("R5 unarmed low load", {31'h0, wdg_rst_req}, 32'h0);
        rd(4'h0, v); check("R5 unarmed value", v, 32'h3F);

        // R6: window compare on reload.
        do_reset();
        wr(4'h4, 32'h50);
        wr(4'h0, 32'hFF);
        wr(4'h0, 32'hFF);
        check("R6 early reload", {31'h0, wdg_rst_req}, 32'h1);
        @(negedge clk);
        rd(4'h4, v); check("R7 cfg reset", v, 32'h7F);
        do_reset();
        wr(4'h4, 32'h50);
        wr(4'h0, 32'hD1);
        wr(4'h0, 32'hFF);
        check("R6 one above window", {31'h0, wdg_rst_req}, 32'h1);
        do_reset();
        wr(4'h4, 32'h50);
        wr(4'h0, 32'hD0);
        wr(4'h0, 32'hFF);
        check("R6 at window legal", {31'h0, wdg_rst_req}, 32'h0);
        rd(4'h0, v); check("R6 reload value", v, 32'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule